// File: doc/BRIEF.md
# Daisy-Chain Enumeration Sequencer

This block is the control sequencer for a daisy chain of battery-monitor devices that share one serial link. It does not shift bits or compute checksums. It issues whole frames to a frame shifter and codec over a request/acknowledge handshake, and it reads back the decoded frames.

The bring-up command resets and configures every device on the chain. It then points the readback at the lower control register and reads response frames until an all-zero frame marks the end of the chain. Each frame is checked for its position before the chain length is accepted. Two conversion commands are provided: one reads back every channel of every device, and the other reads one channel of one device. Both program the read pointer, start a conversion and then wait. The wait is computed in hardware from the acquisition-time code, the averaging code and the discovered chain length, and is counted in microsecond ticks. A shutdown command powers the whole chain down.

The host issues one command at a time. While busy, the block ignores further commands. The host then reads the outcome from the `done` pulse, the 2-bit error code and the slave count.

Top module: `chain_enum_seq`

## Requirements
- R1: After reset, busy, done, err_code, slave_count and fr_req are all 0. A command (cmd_op 00 bring-up, 01 read all, 10 read one, 11 shutdown) is accepted only while the block is idle, and busy then stays high until the cycle in which done pulses for exactly one cycle. A command presented while busy has no effect: no frame is issued for it.
- R2: Bring-up issues three broadcast writes, each to device field 0 with fr_bcast=1. The first goes to register 0x0E with data {1,acq,1,0,1,0,1} (bit 7 is software reset, bits 6:5 are the acquisition code, bits 4, 2 and 0 are set). The second goes to register 0x0E with the same data and bit 7 cleared. The third goes to register 0x1C with data 0x38.
- R3: During enumeration the block reads frames at positions 0, 1, 2 and so on. An all-zero frame at position n≥1 ends the command with err_code 0 and slave_count n−1. The zero test is made before the CRC test.
- R4: A non-zero frame with fr_crc_ok=0 during enumeration ends the command with err_code 1. slave_count is kept unchanged.
- R5: A frame whose address field fr_rdata[31:27], taken in transmit order and bit-reversed, does not equal its position ends enumeration with err_code 2.
- R6: Enumeration ends with err_code 3 in two cases: a zero frame at position 0, or nine non-zero valid frames (positions 0 to 8). In the second case exactly nine reads are made.
- R7: Read all issues a broadcast write of 0x00 to register 0x1C. It then issues a broadcast write to register 0x0D with data {0000,1,avg,0}, waits, and reads (slave_count+1)×12 frames. Each frame is presented on res_frame with a one-cycle res_valid pulse, one cycle after its acknowledge.
- R8: Read one targets device field bitrev5(cmd_dev) with fr_bcast=0. It issues, in order:
  1. a targeted write of {00,cmd_reg,00} to register 0x1C;
  2. a broadcast write of {0011,0,avg,0} to register 0x0D;
  3. a targeted write of {0000,1,avg,0} to register 0x0D.
  It then waits and reads one frame.
- R9: The wait lasts N microseconds, where N = ceil(W/1000) and W = (tacq+695)·12·2^avg − tacq + slave_count·250 + 5000 ns. The codes map as follows: acq codes 0 to 3 give tacq = 465, 1010, 1460 and 1890 ns; avg codes 0 to 3 give 1, 2, 4 and 8 averages. Between the acknowledge of the start write and the first read request, the block is busy with fr_req low for N·(CLK_HZ/10^6)+1 cycles.
- R10: Shutdown issues a single broadcast write to register 0x0D with data {00000,avg,1}.
- R11: fr_crc_ok=0 on a conversion read ends the command at once with err_code 1. No res_valid pulse is produced for that frame.
- R12: While fr_req is high and fr_ack is low, fr_req and all frame fields stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 bring-up, 01 read all, 10 read one, 11 shutdown |
| cmd_dev | input | 3 | Chain position for read one |
| cmd_reg | input | 4 | Channel register for read one |
| cmd_acq | input | 2 | Acquisition-time code |
| cmd_avg | input | 2 | Averaging code |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err_code | output | 2 | 0 ok, 1 CRC, 2 address, 3 chain end |
| slave_count | output | 3 | Devices beyond the first, from last good bring-up |
| fr_req | output | 1 | Frame request |
| fr_rd | output | 1 | Request is a read frame |
| fr_dev | output | 5 | Device address field, transmit order |
| fr_reg | output | 6 | Register address |
| fr_data | output | 8 | Write data |
| fr_bcast | output | 1 | Write applies to all devices |
| fr_ack | input | 1 | Frame complete |
| fr_rdata | input | 32 | Received frame, valid with fr_ack |
| fr_crc_ok | input | 1 | Codec CRC result, valid with fr_ack |
| res_valid | output | 1 | Conversion result strobe |
| res_frame | output | 32 | Conversion result frame |

## Verification
A wrong state or step counter shows up as a wrong frame field, or as an extra or missing frame, at the very next request. Logging every written frame therefore catches it within one handshake. An off-by-one in the position counter or the bit reversal turns a valid chain into error code 2 at the first frame that differs, or shifts slave_count by one at the terminator. A fault in the wait arithmetic only appears as the length of the silent gap before the first read. That gap is measured to the exact cycle for two different settings, so an error of a single tick or a single microsecond is seen as soon as that read is requested.

// File: rtl/chain_enum_seq.sv
module chain_enum_seq #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int MAX_DEV    = 8,
  parameter int CH_PER_DEV = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [2:0]  cmd_dev,
  input  logic [3:0]  cmd_reg,
  input  logic [1:0]  cmd_acq,
  input  logic [1:0]  cmd_avg,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err_code,
  output logic [2:0]  slave_count,
  output logic        fr_req,
  output logic        fr_rd,
  output logic [4:0]  fr_dev,
  output logic [5:0]  fr_reg,
  output logic [7:0]  fr_data,
  output logic        fr_bcast,
  input  logic        fr_ack,
  input  logic [31:0] fr_rdata,
  input  logic        fr_crc_ok,
  output logic        res_valid,
  output logic [31:0] res_frame
);

  localparam int POS_W   = $clog2(MAX_DEV + 1);
  localparam int CNT_W   = $clog2(MAX_DEV * CH_PER_DEV + 1);
  localparam int TICK    = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int TICK_W  = (TICK > 1) ? $clog2(TICK) : 1;
  localparam int NS_W    = 20;
  localparam int CONV_NS = 695;
  localparam int RES_BITS = 12;
  localparam int SLAVE_NS = 250;
  localparam int GUARD_NS = 5000;
  localparam logic [5:0] REG_HI = 6'h0D;
  localparam logic [5:0] REG_LO = 6'h0E;
  localparam logic [5:0] REG_PTR = 6'h1C;

  typedef enum logic [3:0] {
    S_IDLE, S_B_RST, S_B_CFG, S_B_PTR, S_B_RD,
    S_C_PTR, S_C_OFF, S_C_GO, S_WAIT, S_C_RD, S_PD
  } state_t;

  state_t state;
  logic [2:0]        dev_q;
  logic [3:0]        reg_q;
  logic [1:0]        acq_q, avg_q;
  logic              single_q;
  logic [POS_W-1:0]  pos;
  logic [CNT_W-1:0]  rd_cnt, total;
  logic [TICK_W-1:0] tick;
  logic [NS_W-1:0]   ns_acc, acq_ns, per_conv, wait_ns;
  logic [4:0]        tgt;

  function automatic logic [4:0] rev5(input logic [4:0] a);
    for (int i = 0; i < 5; i++) rev5[i] = a[4-i];
  endfunction

  assign busy = (state != S_IDLE);
  assign tgt  = rev5({2'b00, dev_q});
  assign total = single_q ? CNT_W'(1)
                          : CNT_W'((CNT_W'(slave_count) + CNT_W'(1)) * CNT_W'(CH_PER_DEV));

  always_comb begin
    case (acq_q)
      2'd0: acq_ns = NS_W'(465);
      2'd1: acq_ns = NS_W'(1010);
      2'd2: acq_ns = NS_W'(1460);
      default: acq_ns = NS_W'(1890);
    endcase
  end
  assign per_conv = NS_W'((acq_ns + NS_W'(CONV_NS)) * NS_W'(RES_BITS));
  assign wait_ns  = (per_conv << avg_q) - acq_ns
                  + NS_W'(slave_count) * NS_W'(SLAVE_NS) + NS_W'(GUARD_NS);

  always_comb begin
    fr_req = 1'b1; fr_rd = 1'b0; fr_dev = 5'd0; fr_reg = REG_HI;
    fr_data = 8'd0; fr_bcast = 1'b1;
    case (state)
      S_B_RST: begin fr_reg = REG_LO; fr_data = {1'b1, acq_q, 5'b10101}; end
      S_B_CFG: begin fr_reg = REG_LO; fr_data = {1'b0, acq_q, 5'b10101}; end
      S_B_PTR: begin fr_reg = REG_PTR; fr_data = {REG_LO, 2'b00}; end
      S_B_RD, S_C_RD: begin fr_rd = 1'b1; fr_reg = 6'd0; fr_bcast = 1'b0; end
      S_C_PTR: begin
        fr_reg = REG_PTR;
        if (single_q) begin
          fr_dev = tgt; fr_bcast = 1'b0; fr_data = {2'b00, reg_q, 2'b00};
        end
      end
      S_C_OFF: fr_data = {4'b0011, 1'b0, avg_q, 1'b0};
      S_C_GO: begin
        fr_data = {4'b0000, 1'b1, avg_q, 1'b0};
        if (single_q) begin fr_dev = tgt; fr_bcast = 1'b0; end
      end
      S_PD: fr_data = {5'b00000, avg_q, 1'b1};
      default: begin fr_req = 1'b0; fr_reg = 6'd0; fr_bcast = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; done <= 1'b0; err_code <= 2'd0; slave_count <= '0;
      dev_q <= '0; reg_q <= '0; acq_q <= '0; avg_q <= '0; single_q <= 1'b0;
      pos <= '0; rd_cnt <= '0; tick <= '0; ns_acc <= '0;
      res_valid <= 1'b0; res_frame <= '0;
    end else begin
      done <= 1'b0;
      res_valid <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          dev_q <= cmd_dev; reg_q <= cmd_reg; acq_q <= cmd_acq; avg_q <= cmd_avg;
          single_q <= (cmd_op == 2'b10);
          err_code <= 2'd0;
          case (cmd_op)
            2'b00: state <= S_B_RST;
            2'b11: state <= S_PD;
            default: state <= S_C_PTR;
          endcase
        end
        S_B_RST: if (fr_ack) state <= S_B_CFG;
        S_B_CFG: if (fr_ack) state <= S_B_PTR;
        S_B_PTR: if (fr_ack) begin state <= S_B_RD; pos <= '0; end
        S_B_RD: if (fr_ack) begin
          if (fr_rdata == 32'd0) begin
            state <= S_IDLE; done <= 1'b1;
            if (pos == '0) err_code <= 2'd3;
            else slave_count <= 3'(pos - POS_W'(1));
          end else if (!fr_crc_ok) begin
            state <= S_IDLE; done <= 1'b1; err_code <= 2'd1;
          end else if (rev5(fr_rdata[31:27]) != 5'(pos)) begin
            state <= S_IDLE; done <= 1'b1; err_code <= 2'd2;
          end else if (pos == POS_W'(MAX_DEV)) begin
            state <= S_IDLE; done <= 1'b1; err_code <= 2'd3;
          end else begin
            pos <= pos + POS_W'(1);
          end
        end
        S_C_PTR: if (fr_ack) state <= single_q ? S_C_OFF : S_C_GO;
        S_C_OFF: if (fr_ack) state <= S_C_GO;
        S_C_GO: if (fr_ack) begin
          state <= S_WAIT; tick <= '0; ns_acc <= '0;
        end
        S_WAIT: begin
          if (ns_acc >= wait_ns) begin
            state <= S_C_RD; rd_cnt <= '0;
          end else if (tick == TICK_W'(TICK - 1)) begin
            tick <= '0; ns_acc <= ns_acc + NS_W'(1000);
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        S_C_RD: if (fr_ack) begin
          if (!fr_crc_ok) begin
            state <= S_IDLE; done <= 1'b1; err_code <= 2'd1;
          end else begin
            res_valid <= 1'b1; res_frame <= fr_rdata;
            if (rd_cnt == total - CNT_W'(1)) begin
              state <= S_IDLE; done <= 1'b1;
            end else begin
              rd_cnt <= rd_cnt + CNT_W'(1);
            end
          end
        end
        S_PD: if (fr_ack) begin state <= S_IDLE; done <= 1'b1; end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_req && !fr_ack) |=> (fr_req && $stable({fr_rd, fr_dev, fr_reg, fr_data, fr_bcast})));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fr_req);

  // R3
  slave_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_count != $past(slave_count)) |-> (done && err_code == 2'd0));

  // R7
  res_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(fr_ack && fr_rd && fr_crc_ok));

endmodule

// File: tb/chain_enum_seq_test.sv
`timescale 1ns/1ps
module chain_enum_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cmd_dev = 3'd0;
  logic [3:0] cmd_reg = 4'd0;
  logic [1:0] cmd_acq = 2'd0, cmd_avg = 2'd0;
  logic busy, done, fr_req, fr_rd, fr_bcast, res_valid;
  logic [1:0] err_code;
  logic [2:0] slave_count;
  logic [4:0] fr_dev;
  logic [5:0] fr_reg;
  logic [7:0] fr_data;
  logic [31:0] res_frame;
  logic fr_ack = 1'b0;
  logic [31:0] fr_rdata = 32'd0;
  logic fr_crc_ok = 1'b0;

  always #4 clk = ~clk;

  chain_enum_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_acq(cmd_acq), .cmd_avg(cmd_avg),
    .busy(busy), .done(done), .err_code(err_code), .slave_count(slave_count),
    .fr_req(fr_req), .fr_rd(fr_rd), .fr_dev(fr_dev), .fr_reg(fr_reg),
    .fr_data(fr_data), .fr_bcast(fr_bcast), .fr_ack(fr_ack), .fr_rdata(fr_rdata),
    .fr_crc_ok(fr_crc_ok), .res_valid(res_valid), .res_frame(res_frame));

  int checks = 0, fails = 0;
  logic [31:0] resp_frame [0:127];
  logic        resp_crc   [0:127];
  logic [4:0]  wl_dev [0:15];
  logic [5:0]  wl_reg [0:15];
  logic [7:0]  wl_data [0:15];
  logic        wl_bc [0:15];
  logic [31:0] res_log [0:127];
  int wr_n = 0, rd_n = 0, res_n = 0, waitcnt = 0, lat = 0;

  function automatic logic [4:0] rev5(input logic [4:0] a);
    for (int i = 0; i < 5; i++) rev5[i] = a[4-i];
  endfunction

  function automatic logic [31:0] good(input int p);
    return {rev5(5'(p)), 27'h0ABCDE};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (busy && !fr_req) waitcnt++;
      if (res_valid) begin
        if (res_n < 128) res_log[res_n] = res_frame;
        res_n++;
      end
      if (fr_ack) begin
        fr_ack = 1'b0;
      end else if (fr_req) begin
        if (lat == 2) begin
          lat = 0;
          fr_ack = 1'b1;
          if (fr_rd) begin
            fr_rdata = resp_frame[rd_n % 128];
            fr_crc_ok = resp_crc[rd_n % 128];
            rd_n++;
          end else begin
            if (wr_n < 16) begin
              wl_dev[wr_n] = fr_dev; wl_reg[wr_n] = fr_reg;
              wl_data[wr_n] = fr_data; wl_bc[wr_n] = fr_bcast;
            end
            wr_n++;
          end
        end else lat++;
      end else lat = 0;
    end
  end

  task automatic clear_logs();
    wr_n = 0; rd_n = 0; res_n = 0; waitcnt = 0;
    for (int i = 0; i < 128; i++) begin
      resp_frame[i] = 32'h0; resp_crc[i] = 1'b1;
    end
  endtask

  task automatic start_cmd(input logic [1:0] op, input logic [2:0] dv,
                           input logic [3:0] rg, input logic [1:0] acq,
                           input logic [1:0] avg);
    @(negedge clk);
    cmd_op = op; cmd_dev = dv; cmd_reg = rg; cmd_acq = acq; cmd_avg = avg;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int guard = 0;
    while (!done && guard < 60000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk({tag, " R1 done one cycle"}, {31'd0, done}, 32'd0);
    chk({tag, " R1 idle after done"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic chk_wr(input string tag, input int i, input logic [4:0] dv,
                        input logic [5:0] rg, input logic [7:0] d, input logic bc);
    chk({tag, " dev"}, 32'(wl_dev[i]), 32'(dv));
    chk({tag, " reg"}, 32'(wl_reg[i]), 32'(rg));
    chk({tag, " data"}, 32'(wl_data[i]), 32'(d));
    chk({tag, " bcast"}, 32'(wl_bc[i]), 32'(bc));
  endtask

  task automatic t_reset();
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset err", 32'(err_code), 0);
    chk("R1 reset slaves", 32'(slave_count), 0);
    chk("R1 reset req", 32'(fr_req), 0);
  endtask

  task automatic t_bringup_ok();
    clear_logs();
    for (int i = 0; i < 3; i++) resp_frame[i] = good(i);
    start_cmd(2'b00, 3'd0, 4'd0, 2'd1, 2'd0);
    wait_done("R2");
    chk("R2 write count", 32'(wr_n), 3);
    chk_wr("R2 reset write", 0, 5'd0, 6'h0E, 8'hB5, 1'b1);
    chk_wr("R2 config write", 1, 5'd0, 6'h0E, 8'h35, 1'b1);
    chk_wr("R2 pointer write", 2, 5'd0, 6'h1C, 8'h38, 1'b1);
    chk("R3 read count", 32'(rd_n), 4);
    chk("R3 err", 32'(err_code), 0);
    chk("R3 slave count", 32'(slave_count), 2);
  endtask

  task automatic t_crc();
    clear_logs();
    resp_frame[0] = good(0); resp_frame[1] = good(1); resp_crc[1] = 1'b0;
    start_cmd(2'b00, 3'd0, 4'd0, 2'd0, 2'd0);
    wait_done("R4");
    chk("R4 err", 32'(err_code), 1);
    chk("R4 reads", 32'(rd_n), 2);
    chk("R4 slave kept", 32'(slave_count), 2);
  endtask

  task automatic t_addr();
    clear_logs();
    resp_frame[0] = good(0); resp_frame[1] = good(2);
    start_cmd(2'b00, 3'd0, 4'd0, 2'd0, 2'd0);
    wait_done("R5");
    chk("R5 err", 32'(err_code), 2);
    chk("R5 reads", 32'(rd_n), 2);
  endtask

  task automatic t_noterm();
    clear_logs();
    for (int i = 0; i < 12; i++) resp_frame[i] = good(i);
    start_cmd(2'b00, 3'd0, 4'd0, 2'd0, 2'd0);
    wait_done("R6");
    chk("R6 err no terminator", 32'(err_code), 3);
    chk("R6 nine reads", 32'(rd_n), 9);
    clear_logs();
    start_cmd(2'b00, 3'd0, 4'd0, 2'd0, 2'd0);
    wait_done("R6");
    chk("R6 err zero at 0", 32'(err_code), 3);
    chk("R6 one read", 32'(rd_n), 1);
    chk("R6 slave kept", 32'(slave_count), 2);
  endtask

  task automatic t_readall_ignore();
    clear_logs();
    for (int i = 0; i < 40; i++) resp_frame[i] = 32'h100 + 32'(i * 7);
    start_cmd(2'b01, 3'd0, 4'd0, 2'd0, 2'd0);
    repeat (40) @(negedge clk);
    cmd_op = 2'b11; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done("R7");
    chk("R1 ignored cmd writes", 32'(wr_n), 2);
    chk_wr("R7 pointer write", 0, 5'd0, 6'h1C, 8'h00, 1'b1);
    chk_wr("R7 start write", 1, 5'd0, 6'h0D, 8'h08, 1'b1);
    chk("R9 wait cycles read all", 32'(waitcnt), 19 * 125 + 1);
    chk("R7 reads", 32'(rd_n), 36);
    chk("R7 results", 32'(res_n), 36);
    chk("R7 first result", res_log[0], 32'h100);
    chk("R7 last result", res_log[35], 32'h100 + 35 * 7);
    chk("R7 err", 32'(err_code), 0);
  endtask

  task automatic t_single();
    clear_logs();
    resp_frame[0] = 32'hC0FFEE11;
    start_cmd(2'b10, 3'd3, 4'd5, 2'd3, 2'd3);
    wait_done("R8");
    chk("R8 write count", 32'(wr_n), 3);
    chk_wr("R8 pointer write", 0, 5'd24, 6'h1C, 8'h14, 1'b0);
    chk_wr("R8 off write", 1, 5'd0, 6'h0D, 8'h36, 1'b1);
    chk_wr("R8 start write", 2, 5'd24, 6'h0D, 8'h0E, 1'b0);
    chk("R9 wait cycles single", 32'(waitcnt), 252 * 125 + 1);
    chk("R8 reads", 32'(rd_n), 1);
    chk("R8 result", res_log[0], 32'hC0FFEE11);
    chk("R8 results", 32'(res_n), 1);
  endtask

  task automatic t_convcrc();
    clear_logs();
    for (int i = 0; i < 40; i++) resp_frame[i] = 32'h55 + 32'(i);
    resp_crc[3] = 1'b0;
    start_cmd(2'b01, 3'd0, 4'd0, 2'd0, 2'd0);
    wait_done("R11");
    chk("R11 err", 32'(err_code), 1);
    chk("R11 reads", 32'(rd_n), 4);
    chk("R11 results", 32'(res_n), 3);
  endtask

  task automatic t_shutdown();
    clear_logs();
    start_cmd(2'b11, 3'd0, 4'd0, 2'd0, 2'd2);
    wait_done("R10");
    chk("R10 write count", 32'(wr_n), 1);
    chk_wr("R10 powerdown write", 0, 5'd0, 6'h0D, 8'h05, 1'b1);
    chk("R10 err", 32'(err_code), 0);
    chk("R10 reads", 32'(rd_n), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual busy %0d expected run to end", busy);
    finish_run();
  end

  initial begin
    clear_logs();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bringup_ok();
    t_crc();
    t_addr();
    t_noterm();
    t_readall_ignore();
    t_single();
    t_convcrc();
    t_shutdown();
    finish_run();
  end
endmodule